// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral counts down in half-second steps and demands periodic proof of life from software. A 16-bit register port with write strobes and a combinational read path holds a control word with a timeout field, enable, reset-routing and suspend bits. It also holds a service word that takes a two-word key, a reset-cause word, and a miscellaneous word that switches off an early power-down pulse. An external tick input advances all timing by one half-second per pulse. A test environment can therefore run time much faster than the slow clock would.

Software writes a timeout value F and sets the enable bit. From then on it must write the first key word and then the second key word to the service register. Each complete key pair restores the count. If F+1 ticks pass without a complete key pair, the timer expires. On expiry it records the cause and, when routed to do so, raises a reset request.

Software can also request a system reset through an active-low control bit. The block honours that request only after two such writes land inside one tick period.

Top module: `wdogTop`

## Requirements
- R1: After power-on reset, the control register (offset 0x0) reads 0x0010, the status register (offset 0x4) reads 0x0000 and the misc register (offset 0x8) reads 0x0001. The outputs rstReq and swRstReq are low and pdnOutN is high.
- R2: The control register holds the timeout field F in bits 15:8 and the enable in bit 2. After the write that sets the enable, the timer expires on the (F+1)-th tick and not before.
- R3: Writing 0x5555 to the service register (offset 0x2) and then 0xAAAA as the very next service write reloads the count with the current F. Any other service word in between, or the two words in the reverse order, do not reload.
- R4: Once set, the enable bit stays set. A later control write with bit 2 low reads back with bit 2 high and does not stop the countdown.
- R5: A new F written while the timer runs leaves the current countdown unchanged. The new F takes effect at the next reload.
- R6: Control bit 0 (suspend) is write-once, and the first control write fixes its value. While suspend is 1 and the lowPwr input is high, ticks do not advance the countdown.
- R7: Expiry sets status bit 1. That bit stays set until power-on reset.
- R8: Expiry raises rstReq, which then stays high, when control bit 3 (reset routing) is 0. When bit 3 is 1, rstReq stays low.
- R9: Control bit 4 is an active-low software-reset request and reads as 1 until the request is granted. swRstReq rises only after a second write with bit 4 low that arrives before any tick following the first such write.
- R10: A power-down counter starts at reset. When the tick count reaches PDN_TICKS, pdnOutN goes low for exactly one clock. Writing 0x0000 to the misc register before then disables the counter, and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| tickEn | input | 1 | One-clock pulse per half-second |
| lowPwr | input | 1 | Chip is in a low-power state |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr, combinational |
| rstReq | output | 1 | Expiry reset request, sticky |
| swRstReq | output | 1 | Software reset request, sticky |
| pdnOutN | output | 1 | Power-down pulse, active low |

## Verification
The expiry path is swept over every timeout value from 0 to 15. Each run checks that the output is quiet after F ticks and raised after F+1, which separates an off-by-one in the reload value from one in the zero test. The key checker is driven with the correct pair, an intruding word and a reversed pair, which separates exact-sequence matching from simple matching of the second word. Further patterns apply a field change before and after a key pair, suspend with and without lowPwr, software-reset writes with and without a tick between them, and the power-down pulse both enabled and disabled.

// File: rtl/wdogPkg.sv
package wdogPkg;
  localparam int FIELD_W = 8;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_MISC = 4'h8;

  localparam logic [DATA_W-1:0] KEY_A = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_B = 16'hAAAA;

  localparam int BIT_SUSP = 0;
  localparam int BIT_EN   = 2;
  localparam int BIT_WRE  = 3;
  localparam int BIT_SWRN = 4;
  localparam int BIT_CAUSE = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic               reload;
    logic [FIELD_W-1:0] loadVal;
    logic               run;
    logic               freeze;
    logic               pdnOn;
  } wdogStrobeT;
endpackage

// File: rtl/wdogCtrl.sv
module wdogCtrl
  import wdogPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              lowPwr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  output wdogStrobeT        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq,
  output logic              swRstReq
);
  logic [FIELD_W-1:0] fieldReg;
  logic enBit, wreBit, suspBit, suspDone;
  logic keyArmed, swSeen, causeBit, pdnEn;
  logic ctrlWr, svcWr, miscWr, enRise, keyDone, swWr;

  always_comb begin
    ctrlWr  = wrEn && (addr == ADDR_CTRL);
    svcWr   = wrEn && (addr == ADDR_SVC);
    miscWr  = wrEn && (addr == ADDR_MISC);
    enRise  = ctrlWr && wrData[BIT_EN] && !enBit;
    keyDone = svcWr && keyArmed && (wrData == KEY_B);
    swWr    = ctrlWr && !wrData[BIT_SWRN];
    strobe.reload  = enRise || keyDone;
    strobe.loadVal = ctrlWr ? wrData[DATA_W-1 -: FIELD_W] : fieldReg;
    strobe.run     = enBit;
    strobe.freeze  = suspBit && lowPwr;
    strobe.pdnOn   = pdnEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldReg <= '0;
      enBit    <= 1'b0;
      wreBit   <= 1'b0;
      suspBit  <= 1'b0;
      suspDone <= 1'b0;
    end else if (ctrlWr) begin
      fieldReg <= wrData[DATA_W-1 -: FIELD_W];
      wreBit   <= wrData[BIT_WRE];
      if (wrData[BIT_EN]) enBit <= 1'b1;
      if (!suspDone) begin
        suspBit  <= wrData[BIT_SUSP];
        suspDone <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyArmed <= 1'b0;
    else if (svcWr) keyArmed <= (wrData == KEY_A);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swSeen   <= 1'b0;
      swRstReq <= 1'b0;
    end else if (swWr) begin
      swSeen <= 1'b1;
      if (swSeen) swRstReq <= 1'b1;
    end else if (tickEn) begin
      swSeen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeBit <= 1'b0;
      rstReq   <= 1'b0;
    end else if (expire) begin
      causeBit <= 1'b1;
      if (!wreBit) rstReq <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdnEn <= 1'b1;
    else if (miscWr && (wrData == '0)) pdnEn <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdData[DATA_W-1 -: FIELD_W] = fieldReg;
        rdData[BIT_SWRN] = !swRstReq;
        rdData[BIT_WRE]  = wreBit;
        rdData[BIT_EN]   = enBit;
        rdData[BIT_SUSP] = suspBit;
      end
      ADDR_STAT: rdData[BIT_CAUSE] = causeBit;
      ADDR_MISC: rdData[0] = pdnEn;
      default:   rdData = '0;
    endcase
  end

  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) enBit |=> enBit);
  // R6
  susp_once_chk: assert property (@(posedge clk) disable iff (!rstN) suspDone |=> $stable(suspBit));
  // R7
  cause_set_chk: assert property (@(posedge clk) disable iff (!rstN) expire |=> causeBit);
  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rstN) rstReq |=> rstReq);
  // R9
  sw_two_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(swRstReq) |-> $past(swSeen));
endmodule

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int PDN_TICKS = 32
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  wdogStrobeT strobe,
  output logic       expire,
  output logic       pdnOutN
);
  localparam int PDN_W = $clog2(PDN_TICKS + 1);
  localparam logic [PDN_W-1:0] PDN_LAST = PDN_W'(PDN_TICKS - 1);

  logic [FIELD_W-1:0] cnt;
  logic [PDN_W-1:0]   pdnCnt;
  logic               pdnDone;
  logic               tickGo;

  always_comb begin
    tickGo = tickEn && strobe.run && !strobe.freeze;
    expire = tickGo && (cnt == '0) && !strobe.reload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.reload) cnt <= strobe.loadVal;
    else if (tickGo) cnt <= (cnt == '0) ? strobe.loadVal : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdnCnt  <= '0;
      pdnDone <= 1'b0;
      pdnOutN <= 1'b1;
    end else begin
      pdnOutN <= 1'b1;
      if (tickEn && strobe.pdnOn && !pdnDone) begin
        if (pdnCnt == PDN_LAST) begin
          pdnDone <= 1'b1;
          pdnOutN <= 1'b0;
        end else begin
          pdnCnt <= pdnCnt + 1'b1;
        end
      end
    end
  end

  // R2
  reload_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> cnt == $past(strobe.loadVal));
  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.freeze && !strobe.reload) |=> $stable(cnt));
  // R10
  pdn_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) !pdnOutN |=> pdnOutN);
endmodule

// File: rtl/wdogTop.sv
module wdogTop
  import wdogPkg::*;
#(
  parameter int PDN_TICKS = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              lowPwr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq,
  output logic              swRstReq,
  output logic              pdnOutN
);
  wdogStrobeT strobe;
  logic       expire;

  wdogCtrl uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .lowPwr(lowPwr),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .expire(expire),
    .strobe(strobe), .rdData(rdData), .rstReq(rstReq), .swRstReq(swRstReq)
  );

  wdogDatapath #(.PDN_TICKS(PDN_TICKS)) uPath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .expire(expire), .pdnOutN(pdnOutN)
  );
endmodule

// File: tb/tb_wdogTop.sv
module tb_wdogTop;
  localparam int CLK_PERIOD = 10;
  localparam int PDN = 5;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, lowPwr = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wrData = '0, rdData;
  logic rstReq, swRstReq, pdnOutN;
  int checks = 0, errors = 0, lowSeen = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdogTop #(.PDN_TICKS(PDN)) dut (.*);

  always @(negedge clk) if (rstN && !pdnOutN) lowSeen++;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; wrEn = 1'b0; tickEn = 1'b0; lowPwr = 1'b0;
    @(negedge clk); rstN = 1'b1; lowSeen = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  initial begin
    doReset();
    // R1 reset state
    rd(4'h0, rv); chk("R1 ctrl", rv, 16'h0010);
    rd(4'h4, rv); chk("R1 stat", rv, 16'h0000);
    rd(4'h8, rv); chk("R1 misc", rv, 16'h0001);
    chk("R1 outs", {13'b0, rstReq, swRstReq, pdnOutN}, 16'h0001);

    // R2 R7 sweep of timeout field
    for (int f = 0; f < 16; f++) begin
      doReset();
      wr(4'h8, 16'h0000);
      wr(4'h0, {f[7:0], 8'h14});
      tick(f);
      chk("R2 early", {15'b0, rstReq}, 16'h0000);
      rd(4'h4, rv); chk("R7 clear before", rv, 16'h0000);
      tick(1);
      chk("R2 expire", {15'b0, rstReq}, 16'h0001);
      rd(4'h4, rv); chk("R7 cause", rv, 16'h0002);
    end
    tick(2);
    rd(4'h4, rv); chk("R7 sticky", rv, 16'h0002);
    doReset();
    rd(4'h4, rv); chk("R7 por clears", rv, 16'h0000);

    // R3 key pair reloads
    wr(4'h0, 16'h0314); tick(3);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tick(3); chk("R3 reloaded", {15'b0, rstReq}, 16'h0000);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    tick(1); chk("R3 intruder", {15'b0, rstReq}, 16'h0001);
    doReset();
    wr(4'h0, 16'h0314); tick(3);
    wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555);
    tick(1); chk("R3 reversed", {15'b0, rstReq}, 16'h0001);

    // R4 enable sticky
    doReset();
    wr(4'h0, 16'h0214); wr(4'h0, 16'h0210);
    rd(4'h0, rv); chk("R4 readback", rv & 16'h0004, 16'h0004);
    tick(3); chk("R4 still runs", {15'b0, rstReq}, 16'h0001);

    // R5 field change deferred
    doReset();
    wr(4'h0, 16'h0214); wr(4'h0, 16'h0614);
    tick(3); chk("R5 old field", {15'b0, rstReq}, 16'h0001);
    doReset();
    wr(4'h0, 16'h0214); wr(4'h0, 16'h0614);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tick(6); chk("R5 new early", {15'b0, rstReq}, 16'h0000);
    tick(1); chk("R5 new expire", {15'b0, rstReq}, 16'h0001);

    // R6 suspend write-once and freeze
    doReset();
    wr(4'h0, 16'h0315); wr(4'h0, 16'h0314);
    rd(4'h0, rv); chk("R6 set once", rv & 16'h0001, 16'h0001);
    lowPwr = 1'b1; tick(10);
    chk("R6 frozen", {15'b0, rstReq}, 16'h0000);
    lowPwr = 1'b0; tick(3);
    chk("R6 resume early", {15'b0, rstReq}, 16'h0000);
    tick(1); chk("R6 resume expire", {15'b0, rstReq}, 16'h0001);
    doReset();
    wr(4'h0, 16'h0010); wr(4'h0, 16'h0011);
    rd(4'h0, rv); chk("R6 clear once", rv & 16'h0001, 16'h0000);
    doReset();
    wr(4'h0, 16'h0115); tick(1);
    chk("R6 no lowPwr early", {15'b0, rstReq}, 16'h0000);
    tick(1); chk("R6 no lowPwr expire", {15'b0, rstReq}, 16'h0001);

    // R8 routing bit high
    doReset();
    wr(4'h0, 16'h011C); tick(3);
    chk("R8 routed off", {15'b0, rstReq}, 16'h0000);
    rd(4'h4, rv); chk("R8 cause still", rv, 16'h0002);

    // R9 software reset
    doReset();
    wr(4'h0, 16'h0000); tick(1); wr(4'h0, 16'h0000);
    chk("R9 split by tick", {15'b0, swRstReq}, 16'h0000);
    rd(4'h0, rv); chk("R9 bit reads 1", rv & 16'h0010, 16'h0010);
    wr(4'h0, 16'h0000);
    chk("R9 pair", {15'b0, swRstReq}, 16'h0001);
    rd(4'h0, rv); chk("R9 bit reads 0", rv & 16'h0010, 16'h0000);
    doReset();
    wr(4'h0, 16'h0000); wr(4'h0, 16'h0010);
    chk("R9 single", {15'b0, swRstReq}, 16'h0000);

    // R10 power-down pulse
    doReset();
    tick(PDN - 1);
    chk("R10 no early pulse", 16'(lowSeen), 16'd0);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    chk("R10 low", {15'b0, pdnOutN}, 16'h0000);
    @(negedge clk);
    chk("R10 one cycle", {15'b0, pdnOutN}, 16'h0001);
    tick(4); chk("R10 single pulse", 16'(lowSeen), 16'd1);
    doReset();
    wr(4'h8, 16'h0000);
    rd(4'h8, rv); chk("R10 misc off", rv, 16'h0000);
    tick(2 * PDN); chk("R10 disabled", 16'(lowSeen), 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule